// File: doc/BRIEF.md
# Strobed Serial Voltage-Error Receiver

This block receives the error readings that a remote power stage's analog-to-digital converter sends back on a single data wire. Each reading is a 6-bit word in offset binary. The word gives output voltage minus target voltage. A separate start-of-conversion strobe marks each frame, so no start bit travels on the data line. A frame begins when the strobe has been high for at least two system-clock cycles. The first data bit appears two cycles after the strobe drops. After that a new bit arrives every second cycle, most significant bit first.

The receiver runs on the system clock. Both inputs pass through two-flop synchronisers. A qualifier rejects strobe pulses that are too short. A timing engine samples each bit in the second cycle of its two-cycle slot and assembles the word. The word is published in its raw form and also in two's complement, together with a one-cycle valid pulse. The rate at which readings are delivered therefore equals the strobe rate. A qualified strobe that ends while a frame is still being received aborts that frame and sets a sticky frame-error flag. The receiver then times a fresh frame from the new strobe.

Top module: `verr_rx`

## Requirements
- R1: Both the strobe and the data input pass through two flip-flop stages before any use. For a strobe sampled high on rising edges 0 and 1 and low from edge 2, the valid pulse is high between rising edges 17 and 18, and low before and after.
- R2: A strobe pulse counts only if it stays high for at least 2 consecutive clock samples. A one-cycle pulse when idle starts no frame. A one-cycle pulse during a frame neither disturbs that frame nor sets the frame-error flag.
- R3: The first data bit is taken from the data line two cycles after the strobe's last high sample. Each bit occupies two cycles and is sampled in the second of them. Six bits are taken in order from bit 5 (MSB) down to bit 0.
- R4: The valid output is high for exactly one cycle for each completed frame.
- R5: The raw word and the signed word change only in the cycle in which valid is high, and hold their values between pulses.
- R6: The signed output equals the raw word minus 32 in 6-bit two's complement, which is the raw word with its bit 5 inverted. Raw 0x20 gives 0, 0x3F gives +31 and 0x00 gives -32.
- R7: Suppose a qualified strobe ends before the sixth bit of the current frame has been taken, or ends in the very cycle that bit would be taken. The frame is then dropped without a valid pulse, and a new frame is timed from that strobe.
- R8: A frame error is flagged when R7 applies. The flag stays set until reset.
- R9: Synchronous active-high reset clears the valid output, the frame-error flag and both words to zero.
- R10: Frames whose strobes start 16 cycles apart are each delivered, with their own words.
- R11: A strobe held high longer than 2 cycles is accepted. Data timing is counted from its falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| soc_i | input | 1 | Start-of-conversion strobe from the power stage (asynchronous) |
| err_i | input | 1 | Serial error data from the power stage (asynchronous) |
| err_word_o | output | 6 | Last received word, offset binary |
| err_signed_o | output | 6 | Last received word, two's complement |
| err_valid_o | output | 1 | One-cycle pulse when a new word is published |
| frame_err_o | output | 1 | Sticky flag: a frame was aborted by a new strobe |

## Verification
The critical coincidence is a qualified strobe whose falling edge is detected in exactly the cycle when the sixth bit would be captured. Completion and restart then fall on the same clock edge. The bench provokes this by raising a second two-cycle strobe in the 14th cycle of a frame. It then expects no valid pulse from the first frame, the frame-error flag set, and a correctly timed valid pulse carrying the second frame's word. An earlier mid-frame abort and a one-cycle glitch inside a frame are used as the contrasting cases.

// File: rtl/verr_pkg.sv
package verr_pkg;

    localparam int ERR_W      = 6;  // bits per reading
    localparam int SYNC_DEPTH = 2;  // synchroniser stages
    localparam int SOC_MIN    = 2;  // shortest qualifying strobe, cycles
    localparam int LEAD_CYC   = 2;  // gap from strobe fall to first bit (>= 2)
    localparam int SLOT_CYC   = 2;  // cycles per data bit (>= 2)

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_LEAD = 2'd1,
        RX_DATA = 2'd2
    } rx_state_e;

endpackage

// File: rtl/verr_sync.sv
module verr_sync #(
    parameter int STAGES = verr_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= chain[g-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/verr_soc_qual.sv
module verr_soc_qual #(
    parameter int MIN_HIGH = verr_pkg::SOC_MIN
) (
    input  logic clk,
    input  logic rst,
    input  logic soc_s_i,
    output logic start_o
);
    localparam int CW = $clog2(MIN_HIGH + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_HIGH);

    logic [CW-1:0] hi_cnt;

    // counts consecutive high samples, saturating at the threshold
    always_ff @(posedge clk) begin
        if (rst)               hi_cnt <= '0;
        else if (!soc_s_i)     hi_cnt <= '0;
        else if (hi_cnt != CMAX) hi_cnt <= hi_cnt + 1'b1;
    end

    // a frame starts on the falling edge of a long-enough pulse
    assign start_o = !soc_s_i && (hi_cnt == CMAX);
endmodule

// File: rtl/verr_deser.sv
module verr_deser
    import verr_pkg::*;
#(
    parameter int W    = ERR_W,
    parameter int LEAD = LEAD_CYC,
    parameter int SLOT = SLOT_CYC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o,
    output logic [W-1:0] signed_o,
    output logic         valid_o,
    output logic         abort_o
);
    localparam int TW = $clog2(LEAD + 1);
    localparam int PW = $clog2(SLOT + 1);
    localparam int BW = $clog2(W + 1);
    localparam logic [TW-1:0] LEAD_END = TW'(LEAD - 1);
    localparam logic [PW-1:0] SLOT_END = PW'(SLOT - 1);
    localparam logic [BW-1:0] BIT_END  = BW'(W - 1);

    rx_state_e     state;
    logic [TW-1:0] tmr;
    logic [PW-1:0] ph;
    logic [BW-1:0] bit_cnt;
    logic [W-1:0]  shreg;
    logic [W-1:0]  next_word;
    logic          take_bit;

    assign take_bit  = (state == RX_DATA) && (ph == SLOT_END);
    assign next_word = {shreg[W-2:0], bit_i};

    // a new start always wins; the frame in flight is then dropped
    assign abort_o = start_i && (state != RX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            tmr     <= '0;
            ph      <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (start_i) begin
            state   <= RX_LEAD;
            tmr     <= TW'(1);
            ph      <= '0;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                RX_LEAD: begin
                    if (tmr == LEAD_END) begin
                        state <= RX_DATA;
                        ph    <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (take_bit) begin
                        shreg <= next_word;
                        ph    <= '0;
                        if (bit_cnt == BIT_END) state <= RX_IDLE;
                        else                    bit_cnt <= bit_cnt + 1'b1;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // publish registers
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o   <= '0;
            signed_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (!start_i && take_bit && (bit_cnt == BIT_END)) begin
                word_o   <= next_word;
                signed_o <= {~next_word[W-1], next_word[W-2:0]};
                valid_o  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/verr_rx.sv
module verr_rx
    import verr_pkg::*;
#(
    parameter int W = ERR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         soc_i,
    input  logic         err_i,
    output logic [W-1:0] err_word_o,
    output logic [W-1:0] err_signed_o,
    output logic         err_valid_o,
    output logic         frame_err_o
);
    logic soc_s, err_s, start, abort;

    verr_sync #(.STAGES(SYNC_DEPTH)) u_sync_soc (
        .clk(clk), .rst(rst), .d_i(soc_i), .q_o(soc_s)
    );
    verr_sync #(.STAGES(SYNC_DEPTH)) u_sync_err (
        .clk(clk), .rst(rst), .d_i(err_i), .q_o(err_s)
    );

    verr_soc_qual #(.MIN_HIGH(SOC_MIN)) u_qual (
        .clk(clk), .rst(rst), .soc_s_i(soc_s), .start_o(start)
    );

    verr_deser #(.W(W), .LEAD(LEAD_CYC), .SLOT(SLOT_CYC)) u_deser (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .bit_i    (err_s),
        .word_o   (err_word_o),
        .signed_o (err_signed_o),
        .valid_o  (err_valid_o),
        .abort_o  (abort)
    );

    always_ff @(posedge clk) begin
        if (rst)        frame_err_o <= 1'b0;
        else if (abort) frame_err_o <= 1'b1;
    end
endmodule

// File: rtl/verr_rx_chk.sv
module verr_rx_chk #(
    parameter int W = verr_pkg::ERR_W
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] err_word_o,
    input logic [W-1:0] err_signed_o,
    input logic         err_valid_o,
    input logic         frame_err_o
);
    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid_o |=> !err_valid_o);

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !err_valid_o |-> ($stable(err_word_o) && $stable(err_signed_o)));

    // R6
    signed_form_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid_o |-> ((err_signed_o[W-1] != err_word_o[W-1]) &&
                         (err_signed_o[W-2:0] == err_word_o[W-2:0])));

    // R8
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> frame_err_o);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!err_valid_o && !frame_err_o && (err_word_o == '0)));
endmodule

bind verr_rx verr_rx_chk #(.W(W)) u_verr_rx_chk (
    .clk          (clk),
    .rst          (rst),
    .err_word_o   (err_word_o),
    .err_signed_o (err_signed_o),
    .err_valid_o  (err_valid_o),
    .frame_err_o  (frame_err_o)
);

// File: tb/tb_verr_rx.sv
module tb_verr_rx;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soc_i = 1'b0;
    logic       err_i = 1'b1;
    logic [5:0] err_word_o;
    logic [5:0] err_signed_o;
    logic       err_valid_o;
    logic       frame_err_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    verr_rx dut (
        .clk(clk), .rst(rst), .soc_i(soc_i), .err_i(err_i),
        .err_word_o(err_word_o), .err_signed_o(err_signed_o),
        .err_valid_o(err_valid_o), .frame_err_o(frame_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives one strobe-framed sequence, one cycle per iteration, and
    // records any valid pulses seen (iteration c observes after edge c-1).
    task automatic drive_seq(input logic [5:0] w, input int soclen,
                             input int glitch_at, input int ncyc,
                             output int vcount, output int vcycle,
                             output logic [5:0] vword, output logic [5:0] vsig);
        vcount = 0; vcycle = -1; vword = '0; vsig = '0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (err_valid_o) begin
                vcount++; vcycle = c; vword = err_word_o; vsig = err_signed_o;
            end
            soc_i = (c < soclen) || (c == glitch_at);
            if (c >= soclen + 2 && c < soclen + 14)
                err_i = w[5 - (c - soclen - 2) / 2];
            else
                err_i = 1'b1;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 valid after reset", err_valid_o, 0);
        chk("R9 frame_err after reset", frame_err_o, 0);
        chk("R9 word after reset", err_word_o, 0);
        chk("R9 signed after reset", err_signed_o, 0);
    endtask

    task automatic t_frame(input logic [5:0] w, input int soclen);
        int vc, vcy; logic [5:0] vw, vs;
        drive_seq(w, soclen, -1, soclen + 18, vc, vcy, vw, vs);
        chk("R4 one valid pulse", vc, 1);
        chk("R1 valid cycle", vcy, soclen + 16);
        chk("R3 word", vw, w);
        chk("R6 signed", $signed(vs), int'(w) - 32);
        chk("R5 word held", err_word_o, w);
        if (soclen > 2) chk("R11 long strobe accepted", vw, w);
    endtask

    task automatic t_short_idle();
        int vc, vcy; logic [5:0] vw, vs;
        drive_seq(6'h15, 1, -1, 22, vc, vcy, vw, vs);
        chk("R2 short strobe ignored (no valid)", vc, 0);
        chk("R2 short strobe no frame_err", frame_err_o, 0);
    endtask

    task automatic t_glitch_mid(input logic [5:0] w);
        int vc, vcy; logic [5:0] vw, vs;
        drive_seq(w, 2, 8, 20, vc, vcy, vw, vs);
        chk("R2 glitch: frame still delivered", vc, 1);
        chk("R2 glitch: word intact", vw, w);
        chk("R2 glitch: no frame_err", frame_err_o, 0);
    endtask

    task automatic t_back2back(input logic [5:0] a, input logic [5:0] b);
        int vc, vcy; logic [5:0] vw, vs;
        drive_seq(a, 2, -1, 16, vc, vcy, vw, vs);
        chk("R10 first frame not yet out", vc, 0);
        drive_seq(b, 2, -1, 20, vc, vcy, vw, vs);
        // first frame's pulse falls in iteration 2, second in iteration 18
        chk("R10 two pulses", vc, 2);
        chk("R10 second word", vw, b);
        chk("R10 second cycle", vcy, 18);
    endtask

    task automatic t_abort(input logic [5:0] a, input logic [5:0] b, input int cut);
        int vc, vcy; logic [5:0] vw, vs;
        drive_seq(a, 2, -1, cut, vc, vcy, vw, vs);
        chk("R7 no valid before abort", vc, 0);
        drive_seq(b, 2, -1, 20, vc, vcy, vw, vs);
        chk("R7 aborted frame dropped", vc, 1);
        chk("R7 restart word", vw, b);
        chk("R7 restart timing", vcy, 18);
        chk("R8 frame_err set", frame_err_o, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_frame(6'h20, 2);   // zero error
        t_frame(6'h3F, 2);   // +31
        t_frame(6'h00, 2);   // -32
        t_frame(6'h2D, 2);
        t_short_idle();
        t_glitch_mid(6'h1A);
        t_frame(6'h33, 4);   // R11 long strobe
        t_back2back(6'h0C, 6'h31);
        t_abort(6'h11, 6'h27, 8);   // abort mid-frame
        repeat (5) @(negedge clk);
        chk("R8 frame_err sticky", frame_err_o, 1);
        t_abort(6'h3C, 6'h05, 13);  // strobe ends on final-capture edge
        t_reset();
        chk("R9 frame_err cleared", frame_err_o, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule